// File: doc/BRIEF.md
# Alternating-Sign Restructuring Front End for a Prime-Length Cosine Transform

This block prepares operands for a convolution array that computes a prime-length cosine transform. It accepts a block of N signed samples in natural order. It forms an auxiliary sequence by summing backward from the highest index. Samples at even positions enter that sum with a plus sign and samples at odd positions with a minus sign. It then walks a primitive-root index map and hands the array one operand pair per clock, together with the pair's sum and difference. The first auxiliary value is carried beside every pair, because each transform coefficient later builds on it.

Capture opens on a block-start strobe. When the N-th sample is stored, a single adder runs the backward recursion at one index per clock. After the recursion finishes, the (N-1)/2 operand pairs come out on consecutive cycles. The defaults are N = 7 and primitive root 3. With the default input width of 12 bits, the internal width is 15 bits.

Top module: `restr_front`

## Requirements
- R1: The auxiliary value at the highest index equals the last sample of the block: a(N-1) = x(N-1).
- R2: For i from N-2 down to 0, a(i) = a(i+1) + x(i) when i is even, and a(i) = a(i+1) - x(i) when i is odd.
- R3: Auxiliary values are held in DW + ceil(log2 N) signed bits and never wrap, even for full-scale inputs of alternating polarity.
- R4: Pair number k, for k = 1..H with H = (N-1)/2, holds out_a = a(G^k mod N) and out_b = a(G^(k+H) mod N). Pairs are emitted in increasing k. For N = 7 and G = 3 the index pairs are (3,4), (2,5), (6,1).
- R5: With each pair, out_sum = out_a + out_b and out_diff = out_a - out_b, both one bit wider than the auxiliary values.
- R6: The H pairs of a block appear on H consecutive cycles with out_valid high. out_last is high only on the final pair. out_valid is low at all other times.
- R7: out_x0 carries a(0) of the same block whenever out_valid is high.
- R8: A sample with in_first high is stored as x(0) and restarts capture, discarding a partial block. Samples with in_valid high that arrive while no capture is open are ignored.
- R9: Samples that arrive after a block's N-th sample and before its last pair is emitted are dropped and do not change that block's pairs.
- R10: After reset, out_valid and out_last are low and the data outputs are zero.
- R11: Only cycles with in_valid high advance capture, so idle gaps between the samples of a block do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present on in_data |
| in_first | input | 1 | Marks the sample as x(0) of a new block |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Operand pair valid |
| out_last | output | 1 | Final pair of the block |
| out_a | output | AW | First auxiliary value of the pair |
| out_b | output | AW | Second auxiliary value of the pair |
| out_sum | output | AW+1 | out_a + out_b |
| out_diff | output | AW+1 | out_a - out_b |
| out_x0 | output | AW | Auxiliary value a(0) of the block |

## Verification
Random full blocks, with random idle gaps between samples, exercise the parity-signed recursion and the pairing map together. Any error in the sign rule or in the pair table then shows up as a mismatched sum or difference. Directed blocks of full-scale samples with alternating polarity drive the running sum to its largest magnitude in both directions, which exposes a guard width that is too small. Three further patterns separate the capture rules: samples sent without a start strobe, a partial block cut short by a new start, and a block followed at once by extra samples while it is still being processed. Each of these patterns must leave the emitted pairs equal to those of the intended block only.

// File: rtl/restr_pkg.sv
package restr_pkg;

  // g^e mod n, computed by repeated multiplication (elaboration time only)
  function automatic int pow_mod(input int g, input int e, input int n);
    int r;
    r = 1;
    for (int t = 0; t < e; t++) r = (r * g) % n;
    return r;
  endfunction

  function automatic int guard_bits(input int n);
    return $clog2(n);
  endfunction

endpackage

// File: rtl/restr_capture.sv
module restr_capture #(
  parameter int N  = 7,
  parameter int DW = 12,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hold,
  input  logic                 in_valid,
  input  logic                 in_first,
  input  logic signed [DW-1:0] in_data,
  input  logic [IW-1:0]        rd_idx,
  output logic signed [DW-1:0] rd_data,
  output logic                 full
);

  logic                 open_q;
  logic [IW-1:0]        wr_idx;
  logic [IW-1:0]        wr_sel;
  logic                 take;
  logic signed [DW-1:0] raw [N];

  assign wr_sel  = in_first ? '0 : wr_idx;
  assign take    = !hold && in_valid && (in_first || open_q);
  assign rd_data = raw[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      wr_idx <= '0;
      full   <= 1'b0;
    end else begin
      full <= 1'b0;
      if (take) begin
        if (wr_sel == IW'(N-1)) begin
          open_q <= 1'b0;
          wr_idx <= '0;
          full   <= 1'b1;
        end else begin
          open_q <= 1'b1;
          wr_idx <= wr_sel + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) raw[wr_sel] <= in_data;
  end

  // R8: a start strobe always opens capture, or completes it when N == 1
  a_r8_first_opens: assert property (@(posedge clk) disable iff (rst)
    (take && in_first) |=> (open_q || full));

  // R11: the write index never leaves the block
  a_r11_idx_range: assert property (@(posedge clk) disable iff (rst)
    wr_idx < IW'(N));

endmodule

// File: rtl/restr_recur.sv
module restr_recur #(
  parameter int N  = 7,
  parameter int DW = 12,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int AW = DW + ((N > 1) ? $clog2(N) : 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic signed [DW-1:0] smp,
  output logic [IW-1:0]        smp_idx,
  input  logic [IW-1:0]        rd_i,
  input  logic [IW-1:0]        rd_j,
  output logic signed [AW-1:0] dat_i,
  output logic signed [AW-1:0] dat_j,
  output logic signed [AW-1:0] x0,
  output logic                 busy,
  output logic                 done
);

  logic [IW-1:0]        ridx;
  logic                 first_q;
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] ext;
  logic signed [AW-1:0] term;
  logic signed [AW:0]   wide;
  logic signed [AW-1:0] nxt;
  logic signed [AW-1:0] aux [N];

  assign smp_idx = ridx;
  assign ext     = {{(AW-DW){smp[DW-1]}}, smp};
  assign term    = ridx[0] ? -ext : ext;
  assign wide    = {acc[AW-1], acc} + {term[AW-1], term};
  assign nxt     = first_q ? term : wide[AW-1:0];
  assign dat_i   = aux[rd_i];
  assign dat_j   = aux[rd_j];

  always_ff @(posedge clk) begin
    if (rst) begin
      ridx    <= '0;
      first_q <= 1'b0;
      acc     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      x0      <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        first_q <= 1'b1;
        ridx    <= IW'(N-1);
      end else if (busy) begin
        acc     <= nxt;
        first_q <= 1'b0;
        if (ridx == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
          x0   <= nxt;
        end else begin
          ridx <= ridx - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy) aux[ridx] <= nxt;
  end

  // R3: the running sum never needs a bit beyond the guard width
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (busy && !first_q) |-> (wide[AW] == wide[AW-1]));

  // R1: the recursion always opens at the highest index
  a_r1_starts_high: assert property (@(posedge clk) disable iff (rst)
    (busy && first_q) |-> (ridx == IW'(N-1)));

endmodule

// File: rtl/restr_pairs.sv
module restr_pairs #(
  parameter int N  = 7,
  parameter int G  = 3,
  parameter int DW = 12,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int AW = DW + ((N > 1) ? $clog2(N) : 1),
  localparam int H  = (N - 1) / 2,
  localparam int KW = (H > 1) ? $clog2(H) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic signed [AW-1:0] x0,
  input  logic signed [AW-1:0] dat_i,
  input  logic signed [AW-1:0] dat_j,
  output logic [IW-1:0]        rd_i,
  output logic [IW-1:0]        rd_j,
  output logic                 busy,
  output logic                 out_valid,
  output logic                 out_last,
  output logic signed [AW-1:0] out_a,
  output logic signed [AW-1:0] out_b,
  output logic signed [AW:0]   out_sum,
  output logic signed [AW:0]   out_diff,
  output logic signed [AW-1:0] out_x0
);

  logic [IW-1:0] tab_i [H];
  logic [IW-1:0] tab_j [H];
  logic [KW-1:0] kcnt;
  logic          last_k;

  for (genvar k = 0; k < H; k++) begin : g_map
    localparam int PI = restr_pkg::pow_mod(G, k + 1, N);
    localparam int PJ = restr_pkg::pow_mod(G, k + 1 + H, N);
    assign tab_i[k] = IW'(PI);
    assign tab_j[k] = IW'(PJ);
  end

  assign rd_i   = tab_i[kcnt];
  assign rd_j   = tab_j[kcnt];
  assign last_k = (kcnt == KW'(H-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      kcnt      <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_a     <= '0;
      out_b     <= '0;
      out_sum   <= '0;
      out_diff  <= '0;
      out_x0    <= '0;
    end else begin
      out_valid <= busy;
      out_last  <= busy && last_k;
      if (start && !busy) begin
        busy <= 1'b1;
        kcnt <= '0;
      end else if (busy) begin
        out_a    <= dat_i;
        out_b    <= dat_j;
        out_sum  <= {dat_i[AW-1], dat_i} + {dat_j[AW-1], dat_j};
        out_diff <= {dat_i[AW-1], dat_i} - {dat_j[AW-1], dat_j};
        out_x0   <= x0;
        if (last_k) begin
          busy <= 1'b0;
          kcnt <= '0;
        end else begin
          kcnt <= kcnt + 1'b1;
        end
      end
    end
  end

  // R4: both reads stay inside the block and never name the same entry
  a_r4_index_range: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rd_i < IW'(N) && rd_j < IW'(N) && rd_i != rd_j));

endmodule

// File: rtl/restr_front.sv
module restr_front #(
  parameter int N  = 7,
  parameter int G  = 3,
  parameter int DW = 12,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int AW = DW + ((N > 1) ? $clog2(N) : 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_first,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic                 out_last,
  output logic signed [AW-1:0] out_a,
  output logic signed [AW-1:0] out_b,
  output logic signed [AW:0]   out_sum,
  output logic signed [AW:0]   out_diff,
  output logic signed [AW-1:0] out_x0
);

  logic                 cap_full;
  logic                 rec_busy;
  logic                 rec_done;
  logic                 pair_busy;
  logic                 hold;
  logic [IW-1:0]        smp_idx;
  logic signed [DW-1:0] smp;
  logic [IW-1:0]        rd_i;
  logic [IW-1:0]        rd_j;
  logic signed [AW-1:0] dat_i;
  logic signed [AW-1:0] dat_j;
  logic signed [AW-1:0] x0;

  assign hold = cap_full || rec_busy || rec_done || pair_busy;

  restr_capture #(.N(N), .DW(DW)) u_cap (
    .clk(clk), .rst(rst), .hold(hold),
    .in_valid(in_valid), .in_first(in_first), .in_data(in_data),
    .rd_idx(smp_idx), .rd_data(smp), .full(cap_full)
  );

  restr_recur #(.N(N), .DW(DW)) u_rec (
    .clk(clk), .rst(rst), .start(cap_full),
    .smp(smp), .smp_idx(smp_idx),
    .rd_i(rd_i), .rd_j(rd_j), .dat_i(dat_i), .dat_j(dat_j),
    .x0(x0), .busy(rec_busy), .done(rec_done)
  );

  restr_pairs #(.N(N), .G(G), .DW(DW)) u_pair (
    .clk(clk), .rst(rst), .start(rec_done), .x0(x0),
    .dat_i(dat_i), .dat_j(dat_j), .rd_i(rd_i), .rd_j(rd_j),
    .busy(pair_busy), .out_valid(out_valid), .out_last(out_last),
    .out_a(out_a), .out_b(out_b), .out_sum(out_sum),
    .out_diff(out_diff), .out_x0(out_x0)
  );

  // R5: sum and difference are consistent with the second operand
  a_r5_sumdiff: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sum - out_diff == {out_b, 1'b0}));

  // R6: pairs stream without gaps until the last one
  a_r6_no_gap: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> out_valid);

  // R6: the stream stops right after the last pair
  a_r6_ends: assert property (@(posedge clk) disable iff (rst)
    out_last |=> !out_valid);

  // R7: a(0) stays fixed across the pairs of one block
  a_r7_x0_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> $stable(out_x0));

  // R9: a new block never completes capture while one is in flight
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    (rec_busy || pair_busy) |-> !cap_full);

  // R10: outputs are quiet in the cycle after reset
  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !out_last));

endmodule

// File: tb/restr_front_tb.sv
module restr_front_tb;

  localparam int N  = 7;
  localparam int G  = 3;
  localparam int DW = 12;
  localparam int AW = DW + $clog2(N);
  localparam int H  = (N - 1) / 2;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic                 in_first = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic                 out_valid;
  logic                 out_last;
  logic signed [AW-1:0] out_a;
  logic signed [AW-1:0] out_b;
  logic signed [AW:0]   out_sum;
  logic signed [AW:0]   out_diff;
  logic signed [AW-1:0] out_x0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  restr_front #(.N(N), .G(G), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_data(in_data), .out_valid(out_valid), .out_last(out_last),
    .out_a(out_a), .out_b(out_b), .out_sum(out_sum),
    .out_diff(out_diff), .out_x0(out_x0)
  );

  function automatic int pmod(input int g, input int e, input int n);
    int r = 1;
    for (int t = 0; t < e; t++) r = (r * g) % n;
    return r;
  endfunction

  function automatic void model(input int s[N], output int a[N]);
    a[N-1] = s[N-1];
    for (int i = N - 2; i >= 0; i--)
      a[i] = a[i+1] + (((i % 2) == 1) ? -s[i] : s[i]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_block(input int s[N], input int gap_max, input int count);
    for (int i = 0; i < count; i++) begin
      in_valid = 1'b1;
      in_first = (i == 0);
      in_data  = s[i][DW-1:0];
      @(negedge clk);
      in_valid = 1'b0;
      in_first = 1'b0;
      if (gap_max > 0) repeat ($urandom_range(gap_max)) @(negedge clk);
    end
  endtask

  task automatic expect_block(input int s[N], input string tag);
    int a[N];
    int w = 0;
    model(s, a);
    while (!out_valid && w < 200) begin
      @(negedge clk);
      w++;
    end
    check(out_valid, "R6 pairs appear", int'(out_valid), 1);
    for (int k = 1; k <= H; k++) begin
      int pi = pmod(G, k, N);
      int pj = pmod(G, k + H, N);
      // R1 and R2 are seen through the auxiliary values; R4 through the pairing
      check(int'(out_a) == a[pi], {tag, " R4 R2 out_a"}, int'(out_a), a[pi]);
      check(int'(out_b) == a[pj], {tag, " R4 R1 out_b"}, int'(out_b), a[pj]);
      check(int'(out_sum) == a[pi] + a[pj], {tag, " R5 sum"}, int'(out_sum), a[pi] + a[pj]);
      check(int'(out_diff) == a[pi] - a[pj], {tag, " R5 diff"}, int'(out_diff), a[pi] - a[pj]);
      check(int'(out_x0) == a[0], {tag, " R7 x0"}, int'(out_x0), a[0]);
      check(out_valid && (out_last == (k == H)), {tag, " R6 valid/last"},
            int'({out_valid, out_last}), (k == H) ? 3 : 2);
      @(negedge clk);
    end
    check(!out_valid, {tag, " R6 stops"}, int'(out_valid), 0);
  endtask

  task automatic quiet_window(input int len, input string tag);
    int seen = 0;
    for (int c = 0; c < len; c++) begin
      if (out_valid) seen++;
      @(negedge clk);
    end
    check(seen == 0, tag, seen, 0);
  endtask

  function automatic void rand_block(output int s[N]);
    for (int i = 0; i < N; i++) s[i] = int'($urandom_range(4095)) - 2048;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int s[N];
    int t[N];
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!out_valid && !out_last, "R10 flags", int'({out_valid, out_last}), 0);
    check(out_sum == '0 && out_a == '0, "R10 data", int'(out_sum), 0);
    rst = 1'b0;
    @(negedge clk);

    // R2: small directed ramp
    for (int i = 0; i < N; i++) s[i] = i + 1;
    send_block(s, 0, N);
    expect_block(s, "ramp");

    // R3: full-scale alternating polarity, both directions
    for (int i = 0; i < N; i++) s[i] = ((i % 2) == 0) ? 2047 : -2048;
    send_block(s, 0, N);
    expect_block(s, "R3 maxpos");
    for (int i = 0; i < N; i++) s[i] = ((i % 2) == 0) ? -2048 : 2047;
    send_block(s, 0, N);
    expect_block(s, "R3 maxneg");

    // R11: random blocks with random idle gaps
    for (int b = 0; b < 25; b++) begin
      rand_block(s);
      send_block(s, 3, N);
      expect_block(s, "R11 rand");
    end

    // R8: samples without a start strobe are ignored
    rand_block(s);
    for (int i = 0; i < N; i++) begin
      in_valid = 1'b1;
      in_data  = s[i][DW-1:0];
      @(negedge clk);
    end
    in_valid = 1'b0;
    quiet_window(30, "R8 no strobe no output");

    // R8: a new strobe discards a partial block
    rand_block(t);
    send_block(t, 0, 3);
    rand_block(s);
    send_block(s, 1, N);
    expect_block(s, "R8 restart");

    // R9: samples during processing are dropped
    rand_block(s);
    rand_block(t);
    send_block(s, 0, N);
    send_block(t, 0, 5);
    expect_block(s, "R9 busy drop");
    quiet_window(20, "R9 no ghost block");

    rand_block(s);
    send_block(s, 2, N);
    expect_block(s, "R9 after drop");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule